// File: doc/BRIEF.md
# Dual-Processor Mailbox FIFO

This block lets two processors exchange words and small signal codes. Each processor has its own register port with four registers: a signalling register, a queue control and status register, a write-only transmit port and a read-only receive port. There is one queue in each direction. Each queue is 16 entries deep and 32 bits wide. A word that one side pushes into its transmit queue is taken out by the other side through its receive port.

The two register views are linked. The 4-bit code that one side writes into its signalling register shows up in the low bits of the other side's signalling register. The occupancy of each queue appears in the status bits of both sides at the same moment. Reading from an empty queue does two things: it returns the last word that was read out of that queue successfully, and it latches a sticky error bit. Transmit-queue overflow and an explicit flush are handled locally by the writer.

Each access is a whole 32-bit register access lasting one cycle. Read data comes back registered, one cycle after the request.

Top module: `ipc_mailbox`

## Requirements
- R1: Register select encoding is 0 = signalling, 1 = control, 2 = transmit, 3 = receive. Read data appears on the side's rdata in the cycle after the request. Reading the transmit port returns 0. Writing the receive port has no effect.
- R2: After reset, each control register reads 0x0000_0101 and each signalling register reads 0.
- R3: A signalling-register write keeps only bits 8-11, 13 and 14. Bits 0-3 of each side's signalling register read back the other side's bits 8-11.
- R4: The control layout is: bit 0 transmit empty, bit 1 transmit full, bit 8 receive empty, bit 9 receive full (all four read-only), bit 15 queue enable, bit 14 error, and bits 2 and 10 plain read/write. All other bits read 0.
- R5: Writing control with bit 14 set clears the error bit. Writing control with bit 14 clear leaves the error bit unchanged.
- R6: A transmit write while that side's enable bit is clear is dropped without raising an error.
- R7: Each queue keeps first-in first-out order over 16 entries. A count of 16 sets the writer's transmit-full bit and the reader's receive-full bit.
- R8: A push into a full queue is discarded and sets the writer's error bit.
- R9: A receive read with the reader's enable set removes the head word. With the enable clear, it returns the head word and leaves it in the queue.
- R10: A receive read of an empty queue sets the reader's error bit. It returns the last word read from that queue, or 0 if no word has been read from it yet.
- R11: Writing control with bit 3 set empties that side's transmit queue. Bit 3 always reads 0.
- R12: The writer's transmit-empty and transmit-full bits and the reader's receive-empty and receive-full bits follow the same queue count, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Side A access request |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_sel | input | 2 | Side A register select |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| b_req | input | 1 | Side B access request |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_sel | input | 2 | Side B register select |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |

## Verification
The hardest state to reach from the ports is a queue holding exactly 16 words with one more push arriving. The stimulus writes seventeen words in a row from one side while the other side stays idle. It then drains the queue and checks that the order survived and that the extra word is not there. The disabled-peek and empty-read corners come next. For these, the reader's enable is turned off between pushes, and a queue is drained and then read once more, so that the last-good-word register must supply the returned data.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  typedef enum logic [1:0] {
    SEL_SIG  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_TX   = 2'd2,
    SEL_RX   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_TX_EMPTY = 0;
  localparam int unsigned CTRL_TX_FULL  = 1;
  localparam int unsigned CTRL_NOTE_LO  = 2;
  localparam int unsigned CTRL_FLUSH    = 3;
  localparam int unsigned CTRL_RX_EMPTY = 8;
  localparam int unsigned CTRL_RX_FULL  = 9;
  localparam int unsigned CTRL_NOTE_HI  = 10;
  localparam int unsigned CTRL_ERR      = 14;
  localparam int unsigned CTRL_EN       = 15;
endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;

  always_comb begin
    do_push = push_i && !full_o && !flush_i;
    do_pop  = pop_i && !empty_o && !flush_i;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    cnt_d   = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) wptr_d = bump(wptr_q);
      if (do_pop)  rptr_d = bump(rptr_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data_i;
  end
endmodule

// File: rtl/ipc_mbox_port.sv
module ipc_mbox_port
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [3:0]        peer_code_i,
  output logic [3:0]        code_o,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  input  logic [DATA_W-1:0] rx_head_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              pop_o,
  output logic              flush_o,
  output logic              en_o,
  output logic              err_o
);
  reg_sel_e sel;
  logic acc_wr, acc_rd, rx_read, push_try, push_overflow;
  logic [3:0] code_q, code_d;
  logic [1:0] aux_q, aux_d;
  logic [1:0] note_q, note_d;
  logic en_q, en_d, err_q, err_d;
  logic [DATA_W-1:0] last_q, last_d, rdata_q, rdata_d;
  logic [31:0] sig_view, ctrl_view;

  assign sel    = reg_sel_e'(sel_i);
  assign acc_wr = req_i && we_i;
  assign acc_rd = req_i && !we_i;

  assign push_try      = acc_wr && (sel == SEL_TX) && en_q;
  assign push_o        = push_try && !tx_full_i;
  assign push_overflow = push_try && tx_full_i;
  assign push_data_o   = wdata_i;
  assign rx_read       = acc_rd && (sel == SEL_RX);
  assign pop_o         = rx_read && en_q && !rx_empty_i;
  assign flush_o       = acc_wr && (sel == SEL_CTRL) && wdata_i[CTRL_FLUSH];

  assign sig_view  = {16'b0, 1'b0, aux_q[1], aux_q[0], 1'b0, code_q, 4'b0, peer_code_i};
  assign ctrl_view = {16'b0, en_q, err_q, 3'b0, note_q[1], rx_full_i, rx_empty_i,
                      4'b0, 1'b0, note_q[0], tx_full_i, tx_empty_i};

  always_comb begin
    code_d  = code_q;
    aux_d   = aux_q;
    note_d  = note_q;
    en_d    = en_q;
    err_d   = err_q;
    last_d  = last_q;
    rdata_d = rdata_q;
    if (acc_wr && sel == SEL_SIG) begin
      code_d = wdata_i[11:8];
      aux_d  = wdata_i[14:13];
    end
    if (acc_wr && sel == SEL_CTRL) begin
      en_d   = wdata_i[CTRL_EN];
      note_d = {wdata_i[CTRL_NOTE_HI], wdata_i[CTRL_NOTE_LO]};
      if (wdata_i[CTRL_ERR]) err_d = 1'b0;
    end
    if (push_overflow || (rx_read && rx_empty_i)) err_d = 1'b1;
    if (rx_read && !rx_empty_i) last_d = rx_head_i;
    if (acc_rd) begin
      unique case (sel)
        SEL_SIG:  rdata_d = DATA_W'(sig_view);
        SEL_CTRL: rdata_d = DATA_W'(ctrl_view);
        SEL_TX:   rdata_d = '0;
        SEL_RX:   rdata_d = rx_empty_i ? last_q : rx_head_i;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      aux_q   <= '0;
      note_q  <= '0;
      en_q    <= 1'b0;
      err_q   <= 1'b0;
      last_q  <= '0;
      rdata_q <= '0;
    end else begin
      code_q  <= code_d;
      aux_q   <= aux_d;
      note_q  <= note_d;
      en_q    <= en_d;
      err_q   <= err_d;
      last_q  <= last_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign code_o  = code_q;
  assign en_o    = en_q;
  assign err_o   = err_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [1:0]        a_sel,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [1:0]        b_sel,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              s_req   [2];
  logic              s_we    [2];
  logic [1:0]        s_sel   [2];
  logic [DATA_W-1:0] s_wdata [2];
  logic [DATA_W-1:0] s_rdata [2];
  logic [3:0]        s_code  [2];
  logic              s_push  [2];
  logic [DATA_W-1:0] s_pdata [2];
  logic              s_pop   [2];
  logic              s_flush [2];
  logic              s_en    [2];
  logic              s_err   [2];
  logic [DATA_W-1:0] q_head  [2];
  logic [CW-1:0]     q_cnt   [2];
  logic              q_empty [2];
  logic              q_full  [2];

  assign s_req[0]   = a_req;
  assign s_we[0]    = a_we;
  assign s_sel[0]   = a_sel;
  assign s_wdata[0] = a_wdata;
  assign s_req[1]   = b_req;
  assign s_we[1]    = b_we;
  assign s_sel[1]   = b_sel;
  assign s_wdata[1] = b_wdata;
  assign a_rdata    = s_rdata[0];
  assign b_rdata    = s_rdata[1];

  for (genvar g = 0; g < 2; g++) begin : g_side
    localparam int unsigned P = 1 - g;

    ipc_mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .push_i      (s_push[g]),
      .push_data_i (s_pdata[g]),
      .pop_i       (s_pop[P]),
      .flush_i     (s_flush[g]),
      .head_o      (q_head[g]),
      .count_o     (q_cnt[g]),
      .empty_o     (q_empty[g]),
      .full_o      (q_full[g])
    );

    ipc_mbox_port #(.DATA_W(DATA_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .req_i       (s_req[g]),
      .we_i        (s_we[g]),
      .sel_i       (s_sel[g]),
      .wdata_i     (s_wdata[g]),
      .rdata_o     (s_rdata[g]),
      .peer_code_i (s_code[P]),
      .code_o      (s_code[g]),
      .tx_empty_i  (q_empty[g]),
      .tx_full_i   (q_full[g]),
      .rx_empty_i  (q_empty[P]),
      .rx_full_i   (q_full[P]),
      .rx_head_i   (q_head[P]),
      .push_o      (s_push[g]),
      .push_data_o (s_pdata[g]),
      .pop_o       (s_pop[g]),
      .flush_o     (s_flush[g]),
      .en_o        (s_en[g]),
      .err_o       (s_err[g])
    );
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          a_req,
  input logic          a_we,
  input logic [1:0]    a_sel,
  input logic [31:0]   a_wdata,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic          push0,
  input logic          pop1,
  input logic          flush0,
  input logic          en0,
  input logic          err0,
  input logic [3:0]    code0
);
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_ok)
    (cnt0 <= CW'(DEPTH)) && (cnt1 <= CW'(DEPTH)));

  a_r7_push_counts: assert property (@(posedge clk) disable iff (!rst_ok)
    (push0 && !pop1 && !flush0) |=> (cnt0 == $past(cnt0) + 1'b1));

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_ok)
    flush0 |=> (cnt0 == '0));

  a_r6_drop_disabled: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_req && a_we && a_sel == 2'd2 && !en0 && !pop1) |=> $stable(cnt0));

  a_r10_empty_read_err: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_req && !a_we && a_sel == 2'd3 && cnt1 == '0) |=> err0);

  a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_req && a_we && a_sel == 2'd1 && a_wdata[14]) |=> !err0);

  a_r3_code_capture: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_req && a_we && a_sel == 2'd0) |=> (code0 == $past(a_wdata[11:8])));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_ok  (rst_sync_n),
  .a_req   (a_req),
  .a_we    (a_we),
  .a_sel   (a_sel),
  .a_wdata (a_wdata),
  .cnt0    (q_cnt[0]),
  .cnt1    (q_cnt[1]),
  .push0   (s_push[0]),
  .pop1    (s_pop[1]),
  .flush0  (s_flush[0]),
  .en0     (s_en[0]),
  .err0    (s_err[0]),
  .code0   (s_code[0])
);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_req = 1'b0, a_we = 1'b0, b_req = 1'b0, b_we = 1'b0;
  logic [1:0] a_sel = '0, b_sel = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_sel(a_sel), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_req(b_req), .b_we(b_we), .b_sel(b_sel), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  typedef struct packed {
    logic        side;
    logic        we;
    logic [1:0]  sel;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_0101, 4'd2},   // R2 A control
    '{1'b1, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_0101, 4'd2},   // R2 B control
    '{1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_0000, 4'd2},   // R2 A signalling
    '{1'b0, 1'b0, 2'd3, 32'h0, 1'b1, 32'h0000_0000, 4'd10},  // R10 empty, never read
    '{1'b0, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_4101, 4'd10},  // R10 error latched
    '{1'b0, 1'b1, 2'd1, 32'h4000, 1'b0, 32'h0, 4'd5},
    '{1'b0, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_0101, 4'd5},   // R5 cleared
    '{1'b0, 1'b1, 2'd1, 32'hFFFF_84F7, 1'b0, 32'h0, 4'd4},
    '{1'b0, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_8505, 4'd4},   // R4 stored bits only
    '{1'b0, 1'b1, 2'd1, 32'h8000, 1'b0, 32'h0, 4'd4},
    '{1'b1, 1'b1, 2'd1, 32'h8000, 1'b0, 32'h0, 4'd4},
    '{1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 32'h0, 4'd3},
    '{1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_6F00, 4'd3},   // R3 mask
    '{1'b1, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_000F, 4'd3},   // R3 mirror
    '{1'b1, 1'b1, 2'd0, 32'h0000_0A00, 1'b0, 32'h0, 4'd3},
    '{1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 32'h0000_6F0A, 4'd3},   // R3 mirror back
    '{1'b0, 1'b1, 2'd2, 32'h1111_1111, 1'b0, 32'h0, 4'd7},
    '{1'b0, 1'b1, 2'd2, 32'h2222_2222, 1'b0, 32'h0, 4'd7},
    '{1'b0, 1'b0, 2'd2, 32'h0, 1'b1, 32'h0000_0000, 4'd1},   // R1 transmit reads 0
    '{1'b0, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_8100, 4'd12},  // R12 writer view
    '{1'b1, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_8001, 4'd12},  // R12 reader view
    '{1'b1, 1'b0, 2'd3, 32'h0, 1'b1, 32'h1111_1111, 4'd9},   // R9 pop
    '{1'b1, 1'b0, 2'd3, 32'h0, 1'b1, 32'h2222_2222, 4'd9},   // R9 pop
    '{1'b1, 1'b0, 2'd3, 32'h0, 1'b1, 32'h2222_2222, 4'd10},  // R10 last good
    '{1'b1, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_C101, 4'd10},  // R10 error
    '{1'b1, 1'b1, 2'd1, 32'h8000, 1'b0, 32'h0, 4'd5},
    '{1'b1, 1'b0, 2'd1, 32'h0, 1'b1, 32'h0000_C101, 4'd5},   // R5 bit14 clear keeps
    '{1'b1, 1'b1, 2'd1, 32'hC000, 1'b0, 32'h0, 4'd5}
  };

  task automatic acc(input bit side, input bit we, input logic [1:0] sel,
                     input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    if (!side) begin a_req = 1'b1; a_we = we; a_sel = sel; a_wdata = wd; end
    else       begin b_req = 1'b1; b_we = we; b_sel = sel; b_wdata = wd; end
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    rd = side ? b_rdata : a_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rdchk(input bit side, input logic [1:0] sel, input logic [31:0] exp,
                       input string req);
    logic [31:0] r;
    acc(side, 1'b0, sel, 32'h0, r);
    check(req, r, exp);
  endtask

  task automatic wr(input bit side, input logic [1:0] sel, input logic [31:0] wd);
    logic [31:0] r;
    acc(side, 1'b1, sel, wd, r);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].side, VEC[i].we, VEC[i].sel, VEC[i].wd, r);
      if (VEC[i].chk) check($sformatf("R%0d vec%0d", VEC[i].rq, i), r, VEC[i].exp);
    end
    rdchk(1'b1, 2'd1, 32'h0000_8101, "R5 write-one clears");

    // R1: write to receive port has no effect on B's receive queue
    wr(1'b1, 2'd3, 32'hBAD0_BAD0);
    rdchk(1'b0, 2'd1, 32'h0000_8101, "R1 receive write ignored");

    // R7: fill 16, check full flags on both sides
    for (int i = 0; i < 16; i++) wr(1'b0, 2'd2, 32'h0000_1000 + i);
    rdchk(1'b0, 2'd1, 32'h0000_8102, "R7 writer full");
    rdchk(1'b1, 2'd1, 32'h0000_8201, "R7 reader full");
    // R8: overflow push discarded, error on writer
    wr(1'b0, 2'd2, 32'hDEAD_BEEF);
    rdchk(1'b0, 2'd1, 32'h0000_C102, "R8 overflow error");
    for (int i = 0; i < 16; i++) rdchk(1'b1, 2'd3, 32'h0000_1000 + i, "R7 order");
    rdchk(1'b1, 2'd1, 32'h0000_8101, "R8 overflow word absent");
    wr(1'b0, 2'd1, 32'h0000_C000);

    // R11: flush
    wr(1'b0, 2'd2, 32'h31);
    wr(1'b0, 2'd2, 32'h32);
    wr(1'b0, 2'd2, 32'h33);
    wr(1'b0, 2'd1, 32'h0000_8008);
    rdchk(1'b0, 2'd1, 32'h0000_8101, "R11 writer empty after flush");
    rdchk(1'b1, 2'd1, 32'h0000_8101, "R12 reader empty after flush");
    rdchk(1'b1, 2'd3, 32'h0000_100F, "R11 flushed words not delivered");
    wr(1'b1, 2'd1, 32'h0000_C000);

    // R9: peek while disabled
    wr(1'b1, 2'd1, 32'h0000_0000);
    wr(1'b0, 2'd2, 32'h0000_00AB);
    rdchk(1'b1, 2'd3, 32'h0000_00AB, "R9 peek");
    rdchk(1'b1, 2'd3, 32'h0000_00AB, "R9 peek keeps head");
    rdchk(1'b1, 2'd1, 32'h0000_0001, "R9 still queued");
    wr(1'b1, 2'd1, 32'h0000_8000);
    rdchk(1'b1, 2'd3, 32'h0000_00AB, "R9 pop after enable");
    rdchk(1'b1, 2'd1, 32'h0000_8101, "R9 drained");

    // R6: disabled transmit dropped, no error
    wr(1'b0, 2'd1, 32'h0000_0000);
    wr(1'b0, 2'd2, 32'h0000_0055);
    rdchk(1'b1, 2'd1, 32'h0000_8101, "R6 nothing queued");
    rdchk(1'b0, 2'd1, 32'h0000_0101, "R6 no error");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule